// File: doc/BRIEF.md
# Clock Controller Register File

This block is the software-visible register store of a clock control module. A processor reaches it over a simple valid/ready register bus with 32-bit words and byte addresses. The word index is the byte address shifted right by two. The block holds one control word, two post-divider words, two PLL configuration words and three clock-gating words. A power-management status word and a fixed lock-status constant can be read but not written. Every writable word keeps only the bits its write mask allows. The control word also keeps its fixed-frequency flag set at all times.

A downstream frequency calculator uses the stored words. The block tells it when to recompute by raising a one-cycle `recalc` pulse. This happens on the first cycle after reset. It also happens after every accepted write that can change a frequency: a write to the control, post-divider or PLL words. Writes to the gating words are stored but do not cause a recompute. An access to an index with no register returns zero data and sets the error bit of the response. A write to such an index changes nothing.

Top module: `ccr_regfile`

## Requirements
- R1: After reset these words read back with these values: index 0 = 0x074b0b7d, index 1 = 0xff870b48, index 2 = 0x49fcfe7f, index 4 = 0x04001800, index 6 = 0x04043001, indexes 8, 9 and 10 = 0xffffffff, index 23 = 0x80209828. A PLL word packs its fields as numerator in bits 9:0, integer part in bits 13:10, denominator in bits 25:16 and pre-divider in bits 29:26.
- R2: A write to index 0 stores the data ANDed with 0x3b6fdfff and then ORed with 0x00000004. Bit 2 is the fixed-frequency flag, and it reads as 1 at all times after reset.
- R3: A write to index 1 stores the data ANDed with 0xff9f3fff. A write to index 4 or index 6 stores the data ANDed with 0xbfff3fff.
- R4: Writes to index 2 and to indexes 8, 9 and 10 store all 32 bits unchanged.
- R5: A read of index 18 always returns 0x00004040. A write to index 18 has no effect on later reads of index 18.
- R6: The readable indexes are 0, 1, 2, 4, 6, 8, 9, 10, 18 and 23. The writable indexes are 0, 1, 2, 4, 6, 8, 9 and 10. A read of any other index returns 0 with `rsp_err` = 1. A write to any index that is not writable, including 18 and 23, changes no register and returns `rsp_err` = 1. A response without an error has `rsp_err` = 0. A write response carries zero data.
- R7: `recalc` is high for exactly the one cycle after each accepted write to index 0, 1, 2, 4 or 6. Writes to indexes 8, 9 and 10, and writes that return an error, do not raise it.
- R8: `recalc` is high during the first cycle after reset is released.
- R9: `req_ready` is always 1. `rsp_valid` is high in the cycle after a request is accepted and low in every other cycle. `rsp_rdata` and `rsp_err` are valid while `rsp_valid` is high.
- R10: Address bits 1:0 are ignored. Any byte address selects word index `req_addr >> 2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Access targeted an index with no register of that kind |
| recalc | output | 1 | One-cycle request to recompute clock frequencies |

## Verification
Two situations are the hardest to reach from the ports. The first is the pulse after reset, because it can coincide with the response to a request made in the very first cycle. The second is a run of back-to-back writes that mix frequency, gating and error writes. In that run a pulse must appear for one write and not for its neighbour. The bench releases reset and checks `recalc` in the first and second cycles. It then issues uninterrupted requests with random indexes, random directions and random data. A reference model compares `recalc`, the response and the error bit on every clock. Directed reads and writes of all-ones and all-zeros patterns then expose each mask bit.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int DW      = 32;
    localparam int NSLOT   = 8;
    localparam int FF_BIT  = 2;

    typedef logic [DW-1:0] word_t;

    // storage slots behind the bus indexes
    typedef enum logic [2:0] {
        SL_CTRL, SL_DIV0, SL_DIV1, SL_MPLL, SL_SPLL, SL_GATE0, SL_GATE1, SL_GATE2
    } slot_e;

    // read data source
    typedef enum logic [1:0] {
        SRC_NONE, SRC_BANK, SRC_LOCK, SRC_PMST
    } rsrc_e;

    typedef struct packed {
        logic  rd_ok;
        logic  wr_ok;
        logic  freq;
        rsrc_e src;
        slot_e slot;
    } dec_t;

    // word indexes (byte address >> 2)
    localparam int IX_CTRL  = 0;
    localparam int IX_DIV0  = 1;
    localparam int IX_DIV1  = 2;
    localparam int IX_MPLL  = 4;
    localparam int IX_SPLL  = 6;
    localparam int IX_GATE0 = 8;
    localparam int IX_GATE1 = 9;
    localparam int IX_GATE2 = 10;
    localparam int IX_LOCK  = 18;
    localparam int IX_PMST  = 23;

    localparam word_t LOCK_WORD  = 32'h0000_4040;
    localparam word_t PMST_WORD  = 32'h8020_9828;
    localparam word_t CTRL_MASK  = 32'h3b6f_dfff;
    localparam word_t DIV0_MASK  = 32'hff9f_3fff;
    localparam word_t PLL_MASK   = 32'hbfff_3fff;
    localparam word_t FULL_MASK  = 32'hffff_ffff;

    function automatic word_t pll_word(logic [3:0] pd, logic [9:0] mfd,
                                       logic [3:0] mfi, logic [9:0] mfn);
        return {2'b00, pd, mfd, 2'b00, mfi, mfn};
    endfunction

    function automatic word_t slot_reset(int s);
        case (s)
            0:       return 32'h074b_0b7d;
            1:       return 32'hff87_0b48;
            2:       return 32'h49fc_fe7f;
            3:       return pll_word(4'd1, 10'd0, 4'd6, 10'd0);
            4:       return pll_word(4'd1, 10'd4, 4'd12, 10'd1);
            default: return 32'hffff_ffff;
        endcase
    endfunction

    function automatic word_t slot_mask(int s);
        case (s)
            0:       return CTRL_MASK;
            1:       return DIV0_MASK;
            3, 4:    return PLL_MASK;
            default: return FULL_MASK;
        endcase
    endfunction

    function automatic word_t slot_force(int s);
        word_t f;
        f = '0;
        if (s == 0) f[FF_BIT] = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
    import ccr_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] idx,
    output dec_t             dec
);

    logic hi_zero;

    assign hi_zero = (idx >> 5) == '0;

    always_comb begin
        dec       = '0;
        dec.src   = SRC_NONE;
        dec.slot  = SL_CTRL;
        if (hi_zero) begin
            case (int'(idx[4:0]))
                IX_CTRL:  begin dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.freq = 1'b1; dec.src = SRC_BANK; dec.slot = SL_CTRL;  end
                IX_DIV0:  begin dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.freq = 1'b1; dec.src = SRC_BANK; dec.slot = SL_DIV0;  end
                IX_DIV1:  begin dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.freq = 1'b1; dec.src = SRC_BANK; dec.slot = SL_DIV1;  end
                IX_MPLL:  begin dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.freq = 1'b1; dec.src = SRC_BANK; dec.slot = SL_MPLL;  end
                IX_SPLL:  begin dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.freq = 1'b1; dec.src = SRC_BANK; dec.slot = SL_SPLL;  end
                IX_GATE0: begin dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.src = SRC_BANK; dec.slot = SL_GATE0; end
                IX_GATE1: begin dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.src = SRC_BANK; dec.slot = SL_GATE1; end
                IX_GATE2: begin dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.src = SRC_BANK; dec.slot = SL_GATE2; end
                IX_LOCK:  begin dec.rd_ok = 1'b1; dec.src = SRC_LOCK; end
                IX_PMST:  begin dec.rd_ok = 1'b1; dec.src = SRC_PMST; end
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/ccr_slot.sv
module ccr_slot
    import ccr_pkg::*;
#(
    parameter word_t RST_VAL = '0,
    parameter word_t WMASK   = '1,
    parameter word_t FORCE   = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  word_t d,
    output word_t q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (we) q <= (d & WMASK) | FORCE;
    end

endmodule

// File: rtl/ccr_regbank.sv
module ccr_regbank
    import ccr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  slot_e wr_slot,
    input  word_t wr_data,
    input  slot_e rd_slot,
    output word_t rd_data
);

    word_t q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        ccr_slot #(
            .RST_VAL (slot_reset(g)),
            .WMASK   (slot_mask(g)),
            .FORCE   (slot_force(g))
        ) u_slot (
            .clk (clk),
            .rst (rst),
            .we  (wr_en && (wr_slot == slot_e'(g))),
            .d   (wr_data),
            .q   (q[g])
        );
    end

    assign rd_data = q[rd_slot];

    AST_CTRL_FF_SET: assert property (@(posedge clk) disable iff (rst) q[SL_CTRL][FF_BIT]); // R2
    AST_DIV0_MASKED: assert property (@(posedge clk) disable iff (rst) (q[SL_DIV0] & ~DIV0_MASK) == '0); // R3
    AST_PLL_MASKED:  assert property (@(posedge clk) disable iff (rst) ((q[SL_MPLL] | q[SL_SPLL]) & ~PLL_MASK) == '0); // R3

endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
    import ccr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              recalc
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             fire;
    logic             wr_en;
    logic             boot_q;
    logic             unused_lsb;
    dec_t             dec;
    word_t            bank_rd;
    word_t            rd_val;

    assign req_ready  = 1'b1;
    assign fire       = req_valid && req_ready;
    assign idx        = req_addr[ADDR_W-1:2];
    assign unused_lsb = ^req_addr[1:0];
    assign wr_en      = fire && req_write && dec.wr_ok;

    ccr_decode #(.IDX_W(IDX_W)) u_dec (
        .idx (idx),
        .dec (dec)
    );

    ccr_regbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_slot (dec.slot),
        .wr_data (req_wdata),
        .rd_slot (dec.slot),
        .rd_data (bank_rd)
    );

    always_comb begin
        case (dec.src)
            SRC_BANK: rd_val = bank_rd;
            SRC_LOCK: rd_val = LOCK_WORD;
            SRC_PMST: rd_val = PMST_WORD;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
            recalc    <= 1'b0;
            boot_q    <= 1'b1;
        end else begin
            rsp_valid <= fire;
            rsp_err   <= fire && (req_write ? !dec.wr_ok : !dec.rd_ok);
            rsp_rdata <= (fire && !req_write && dec.rd_ok) ? rd_val : '0;
            recalc    <= boot_q || (wr_en && dec.freq);
            boot_q    <= 1'b0;
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid); // R9
    AST_NO_IDLE_RSP:   assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid); // R9
    AST_ERR_NO_DATA:   assert property (@(posedge clk) disable iff (rst) rsp_err |-> rsp_rdata == '0); // R6
    AST_BAD_READ_ERR:  assert property (@(posedge clk) disable iff (rst) (req_valid && !req_write && !dec.rd_ok) |=> rsp_err); // R6
    AST_LOCK_CONST:    assert property (@(posedge clk) disable iff (rst) (req_valid && !req_write && idx == IDX_W'(IX_LOCK)) |=> rsp_rdata == LOCK_WORD); // R5
    AST_FREQ_RECALC:   assert property (@(posedge clk) disable iff (rst) (wr_en && dec.freq) |=> recalc); // R7
    AST_QUIET_RECALC:  assert property (@(posedge clk) disable iff (rst) (req_valid && req_write && !dec.freq && !boot_q) |=> !recalc); // R7
    AST_BOOT_RECALC:   assert property (@(posedge clk) disable iff (rst) boot_q |=> recalc); // R8

endmodule

// File: tb/tb_ccr_regfile.sv
module tb_ccr_regfile;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rsp_err;
    logic          recalc;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit edge_seen = 0;
    string cur_req = "R9";

    always #5 clk = ~clk;

    ccr_regfile #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .recalc(recalc)
    );

    // ---------------- reference model ----------------
    logic [31:0] mreg [0:23];
    logic        e_valid, e_err, e_recalc, m_boot;
    logic [31:0] e_data;

    function automatic bit m_rd_ok(int ix);
        return ix inside {0, 1, 2, 4, 6, 8, 9, 10, 18, 23};
    endfunction
    function automatic bit m_wr_ok(int ix);
        return ix inside {0, 1, 2, 4, 6, 8, 9, 10};
    endfunction
    function automatic bit m_freq(int ix);
        return ix inside {0, 1, 2, 4, 6};
    endfunction
    function automatic logic [31:0] m_store(int ix, logic [31:0] d);
        case (ix)
            0:       return (d & 32'h3b6fdfff) | 32'h4;
            1:       return d & 32'hff9f3fff;
            4, 6:    return d & 32'hbfff3fff;
            default: return d;
        endcase
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 24; i++) mreg[i] = '0;
        mreg[0] = 32'h074b0b7d; mreg[1] = 32'hff870b48; mreg[2] = 32'h49fcfe7f;
        mreg[4] = 32'h04001800; mreg[6] = 32'h04043001;
        mreg[8] = 32'hffffffff; mreg[9] = 32'hffffffff; mreg[10] = 32'hffffffff;
        mreg[18] = 32'h00004040; mreg[23] = 32'h80209828;
    endtask

    always @(posedge clk) begin
        int ix;
        edge_seen = 1;
        if (rst) begin
            m_reset();
            e_valid = 0; e_err = 0; e_data = '0; e_recalc = 0; m_boot = 1;
        end else begin
            e_recalc = m_boot; m_boot = 0;
            e_valid = req_valid; e_err = 0; e_data = '0;
            ix = int'(req_addr >> 2);
            if (req_valid) begin
                if (req_write) begin
                    if (m_wr_ok(ix)) begin
                        mreg[ix] = m_store(ix, req_wdata);
                        if (m_freq(ix)) e_recalc = 1;
                    end else e_err = 1;
                end else begin
                    if (m_rd_ok(ix)) e_data = mreg[ix];
                    else e_err = 1;
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (edge_seen && !done) begin
            chk({cur_req, " R9 ready"}, {31'b0, req_ready}, 32'd1);
            chk({cur_req, " R9 rsp_valid"}, {31'b0, rsp_valid}, {31'b0, e_valid});
            chk({cur_req, " rsp_err"}, {31'b0, rsp_err}, {31'b0, e_err});
            chk({cur_req, " rsp_rdata"}, rsp_rdata, e_data);
            chk({cur_req, " recalc"}, {31'b0, recalc}, {31'b0, e_recalc});
        end
    end

    task automatic acc(bit wr, logic [AW-1:0] a, logic [31:0] d);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(int ix, logic [31:0] exp, string tag);
        acc(0, AW'(ix << 2), '0);
        chk(tag, rsp_rdata, exp);
        chk(tag, {31'b0, rsp_err}, 32'd0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R1 reset recalc", {31'b0, recalc}, 32'd0);
        rst = 0;
        @(negedge clk);
        chk("R8 recalc after reset", {31'b0, recalc}, 32'd1);
        @(negedge clk);
        chk("R8 recalc single cycle", {31'b0, recalc}, 32'd0);

        // reset values
        rd(0, 32'h074b0b7d, "R1 ctrl");
        rd(1, 32'hff870b48, "R1 div0");
        rd(2, 32'h49fcfe7f, "R1 div1");
        rd(4, 32'h04001800, "R1 mpll");
        rd(6, 32'h04043001, "R1 spll");
        rd(8, 32'hffffffff, "R1 gate0");
        rd(9, 32'hffffffff, "R1 gate1");
        rd(10, 32'hffffffff, "R1 gate2");
        rd(23, 32'h80209828, "R1 pm");

        cur_req = "R2";
        acc(1, 12'h000, 32'hffffffff);
        chk("R2 recalc after ctrl write", {31'b0, recalc}, 32'd1);
        rd(0, 32'h3b6fdfff, "R2 ctrl ones");
        acc(1, 12'h000, 32'h0);
        rd(0, 32'h00000004, "R2 ctrl zeros keeps bit2");

        cur_req = "R3";
        acc(1, 12'h004, 32'hffffffff);
        rd(1, 32'hff9f3fff, "R3 div0 mask");
        acc(1, 12'h010, 32'hffffffff);
        rd(4, 32'hbfff3fff, "R3 mpll mask");
        acc(1, 12'h018, 32'h5555aaaa);
        rd(6, 32'h1555_2aaa, "R3 spll mask");

        cur_req = "R4";
        acc(1, 12'h008, 32'h12345678);
        rd(2, 32'h12345678, "R4 div1 full");
        acc(1, 12'h024, 32'h0);
        chk("R7 no recalc for gate write", {31'b0, recalc}, 32'd0);
        rd(9, 32'h0, "R4 gate1 full");
        acc(1, 12'h028, 32'ha5a5c3c3);
        rd(10, 32'ha5a5c3c3, "R4 gate2 full");

        cur_req = "R5";
        rd(18, 32'h00004040, "R5 lock const");
        acc(1, 12'h048, 32'h0);
        chk("R5 write to lock errors", {31'b0, rsp_err}, 32'd1);
        rd(18, 32'h00004040, "R5 lock unchanged");

        cur_req = "R6";
        acc(0, 12'h00c, '0);
        chk("R6 unmapped read err", {31'b0, rsp_err}, 32'd1);
        chk("R6 unmapped read zero", rsp_rdata, 32'd0);
        acc(1, 12'h05c, 32'h0);
        chk("R6 pm write err", {31'b0, rsp_err}, 32'd1);
        chk("R7 no recalc on error write", {31'b0, recalc}, 32'd0);
        rd(23, 32'h80209828, "R6 pm unchanged");
        acc(0, 12'hffc, '0);
        chk("R6 high index err", {31'b0, rsp_err}, 32'd1);
        acc(1, 12'h044, 32'hdeadbeef);
        chk("R6 unmapped write err", {31'b0, rsp_err}, 32'd1);

        cur_req = "R10";
        rd(1, 32'hff9f3fff, "R10 aligned");
        acc(0, 12'h007, '0);
        chk("R10 low bits ignored", rsp_rdata, 32'hff9f3fff);

        // back-to-back random traffic, model compared each clock (R7 R9)
        cur_req = "R7";
        for (int n = 0; n < 600; n++) begin
            int ix;
            ix = ($urandom_range(0, 9) == 0) ? $urandom_range(24, 1023) : $urandom_range(0, 25);
            req_valid = ($urandom_range(0, 3) != 0);
            req_write = $urandom_range(0, 1);
            req_addr  = AW'((ix << 2) | $urandom_range(0, 3));
            req_wdata = $urandom;
            @(negedge clk);
        end
        req_valid = 0;
        repeat (3) @(negedge clk);

        // reset again mid-run, check reset state and boot pulse
        cur_req = "R1";
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R8 recalc after second reset", {31'b0, recalc}, 32'd1);
        rd(9, 32'hffffffff, "R1 gate1 after second reset");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule